// File: doc/BRIEF.md
# Opcode-Menu SPI Flash Command Sequencer

This block is a command engine for a serial flash device, driven by software through a small register file. Software fills an eight-entry menu of permitted opcodes. It gives each entry a two-bit kind code and loads two prefix opcodes. A cycle is started by writing the control register with the go bit, a menu index, an optional data phase with its byte count, and an atomic flag. The block can only ever send an opcode that is in the menu. The kind code of the chosen entry decides whether a 24-bit address follows the opcode and which way the data phase moves.

In an atomic cycle the engine first sends the selected prefix opcode in a frame of its own. It then sends the main command in a second frame. After that it polls the device with read-status frames until the busy bit reads clear, or until the poll budget runs out. Write data is taken from a 64-byte buffer that software fills before go. Read data lands in the same buffer and is valid once the done flag is set.

The control FSM states are: IDLE (waits for go); PFX (prefix byte); GAP_PFX (one chip-select-high cycle); OPC (menu opcode); ADR (three address bytes); DAT (data bytes); GAP_CMD (end of the main frame); POLL_OP (status opcode 0x05); POLL_RD (status byte); GAP_POLL (evaluates busy and the poll budget); END (reports done, and error if set). The transitions are:
- IDLE→PFX on an atomic go, and IDLE→OPC on any other go.
- PFX→GAP_PFX→OPC.
- OPC→ADR for kinds 2 and 3. Otherwise OPC→DAT when the data phase is on, and OPC→GAP_CMD when it is off.
- ADR→DAT or ADR→GAP_CMD after the third address byte.
- DAT→GAP_CMD after the last data byte.
- GAP_CMD→POLL_OP when atomic, GAP_CMD→END when not.
- POLL_OP→POLL_RD→GAP_POLL.
- GAP_POLL→END when the device is idle or the budget is spent, and GAP_POLL→POLL_OP otherwise.
- END→IDLE.

Top module: `opm_spi_sequencer`

## Requirements
- R1: After reset the status word reads 0, chip select is high, the serial clock is low, and the menu, kind and prefix registers read 0.
- R2: A go write with menu index k (control bits 6:4) opens one chip-select frame whose first byte is menu entry k. Entry k sits in bits 8k+7:8k of the 64-bit menu, formed from the low word (entries 0-3) and the high word (entries 4-7). Bytes go out MSB first with the clock idle low, and the clock toggles only while chip select is low.
- R3: Kind codes sit at bits 2k+1:2k of the kind register, with 0 = read without address, 1 = write without address, 2 = read with address and 3 = write with address. Kinds 2 and 3 send bits 23:16, 15:8 and 7:0 of the address register after the opcode. Kinds 0 and 1 send no address.
- R4: For write kinds with the data phase on (control bit 14), count+1 bytes are sent from the buffer in index order, where count is control bits 13:8. Buffer byte 4w+b is byte lane b (bits 8b+7:8b) of data word w.
- R5: For read kinds with the data phase on, count+1 bytes are clocked in and stored at buffer indices 0..count. During this phase the engine drives 0x00 out.
- R6: With the data phase off, the count field has no effect and the frame ends after the opcode and any address.
- R7: With the atomic bit (control bit 2) set, the engine sends a one-byte frame holding prefix 0 (prefix bits 7:0) or prefix 1 (bits 15:8), chosen by control bit 3. It then sends the main frame. After that it sends frames of opcode 0x05 plus one read byte until bit 0 of that byte is 0, and only then sets done.
- R8: If the device still reports busy after POLL_LIMIT status frames, the cycle ends with both done and error set.
- R9: Status bit 0 reads 1 while a cycle runs. Bit 2 (done) and bit 3 (error) are set by the engine and cleared only by writing 1 to them. Writing 0 to them leaves them unchanged.
- R10: The address register keeps bits 31:24 at 0 on any write, and bits 23:0 take the written value.
- R11: Writing 1 to lock bit 0 freezes the prefix, kind and menu registers until reset. Those registers stay readable and keep serving commands.
- R12: A go write while a cycle runs is ignored, and no extra frame appears on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Write word address: 0 status, 1 control, 2 address, 3 prefix, 4 kinds, 5 menu low, 6 menu high, 7 lock, 16-31 data words |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 5 | Read word address (same map) |
| reg_rdata | output | 32 | Read data, combinational |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong FSM state or counter shows up at the pins within one byte time. It appears as an extra or missing address byte, a data phase that is too long or too short, or a frame boundary where chip select should have stayed low. A scoreboard compares every captured byte and every chip-select rise against the expected stream, so such faults are caught at the first bad item. A corrupted poll counter or a stale device-busy bit changes the number of status frames, and it also changes the error flag read after done. Faults in lock or reserved-bit handling show up on the next register read.

// File: rtl/opm_pkg.sv
package opm_pkg;
    localparam int CNT_W = 6;                 // data byte count field width
    localparam int BUF_BYTES = 1 << CNT_W;    // data buffer depth
    localparam int AW = CNT_W - 2 + 1;        // register word address width

    localparam logic [AW-1:0] RA_STATUS  = AW'(0);
    localparam logic [AW-1:0] RA_CTRL    = AW'(1);
    localparam logic [AW-1:0] RA_ADDR    = AW'(2);
    localparam logic [AW-1:0] RA_PREFIX  = AW'(3);
    localparam logic [AW-1:0] RA_TYPES   = AW'(4);
    localparam logic [AW-1:0] RA_MENU_LO = AW'(5);
    localparam logic [AW-1:0] RA_MENU_HI = AW'(6);
    localparam logic [AW-1:0] RA_LOCK    = AW'(7);

    localparam logic [15:0] CTRL_KEEP   = 16'h7F7C;
    localparam logic [7:0]  POLL_OPCODE = 8'h05;

    typedef enum logic [3:0] {
        S_IDLE, S_PFX, S_GAP_PFX, S_OPC, S_ADR, S_DAT,
        S_GAP_CMD, S_POLL_OP, S_POLL_RD, S_GAP_POLL, S_END
    } seq_state_t;

    typedef struct packed {
        logic [7:0]       opcode;
        logic [1:0]       kind;      // bit1: address phase, bit0: write direction
        logic [7:0]       prefix;
        logic             atomic;
        logic             data_en;
        logic [CNT_W-1:0] last_idx;
        logic [23:0]      addr;
    } cmd_t;
endpackage

// File: rtl/opm_shifter.sv
module opm_shifter #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    localparam int TW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(SCK_HALF - 1);

    logic [7:0]    tx_sh;
    logic [2:0]    bit_n;
    logic [TW-1:0] tick;
    logic          active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh     <= '0;
            rx_byte   <= '0;
            bit_n     <= '0;
            tick      <= '0;
            active    <= 1'b0;
            sclk      <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    tx_sh  <= tx_byte;
                    bit_n  <= '0;
                    tick   <= '0;
                    sclk   <= 1'b0;
                end
            end else if (tick == TICK_LAST) begin
                tick <= '0;
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sclk  <= 1'b0;
                    tx_sh <= {tx_sh[6:0], 1'b0};
                    bit_n <= bit_n + 3'd1;
                    if (bit_n == 3'd7) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end
                end
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    assign mosi = tx_sh[7];

    // R2
    sclk_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> active);
endmodule

// File: rtl/opm_seq.sv
module opm_seq
    import opm_pkg::*;
#(
    parameter int POLL_LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  cmd_t             cmd,
    input  logic [7:0]       buf_rdata,
    output logic [CNT_W-1:0] buf_ridx,
    output logic             buf_we,
    output logic [CNT_W-1:0] buf_widx,
    output logic [7:0]       buf_wdata,
    output logic             busy,
    output logic             done_p,
    output logic             err_p,
    output logic             cs_n,
    output logic             sh_start,
    output logic [7:0]       sh_tx,
    input  logic [7:0]       sh_rx,
    input  logic             sh_done
);
    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);

    seq_state_t       st, nx;
    cmd_t             cq, cur;
    logic [CNT_W-1:0] bcnt, n_bcnt;
    logic [PW-1:0]    polls;
    logic             fbusy, err_q;

    function automatic logic is_byte(seq_state_t s);
        return s inside {S_PFX, S_OPC, S_ADR, S_DAT, S_POLL_OP, S_POLL_RD};
    endfunction

    assign cur = (st == S_IDLE) ? cmd : cq;

    always_comb begin
        nx = st;
        unique case (st)
            S_IDLE:     if (go) nx = cmd.atomic ? S_PFX : S_OPC;
            S_PFX:      if (sh_done) nx = S_GAP_PFX;
            S_GAP_PFX:  nx = S_OPC;
            S_OPC:      if (sh_done) nx = cur.kind[1] ? S_ADR : (cur.data_en ? S_DAT : S_GAP_CMD);
            S_ADR:      if (sh_done && bcnt == CNT_W'(2)) nx = cur.data_en ? S_DAT : S_GAP_CMD;
            S_DAT:      if (sh_done && bcnt == cur.last_idx) nx = S_GAP_CMD;
            S_GAP_CMD:  nx = cur.atomic ? S_POLL_OP : S_END;
            S_POLL_OP:  if (sh_done) nx = S_POLL_RD;
            S_POLL_RD:  if (sh_done) nx = S_GAP_POLL;
            S_GAP_POLL: nx = (!fbusy || polls == POLL_LAST) ? S_END : S_POLL_OP;
            S_END:      nx = S_IDLE;
            default:    nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    assign sh_start = is_byte(nx) && (sh_done || !is_byte(st));
    assign n_bcnt   = (nx == st) ? bcnt + 1'b1 : '0;
    assign buf_ridx = n_bcnt;

    always_comb begin
        unique case (nx)
            S_PFX:   sh_tx = cur.prefix;
            S_OPC:   sh_tx = cur.opcode;
            S_ADR:   sh_tx = (n_bcnt == '0) ? cur.addr[23:16] :
                             (n_bcnt == CNT_W'(1)) ? cur.addr[15:8] : cur.addr[7:0];
            S_DAT:   sh_tx = cur.kind[0] ? buf_rdata : 8'h00;
            S_POLL_OP: sh_tx = POLL_OPCODE;
            default: sh_tx = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq    <= '0;
            bcnt  <= '0;
            polls <= '0;
            fbusy <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (st == S_IDLE && go) begin
                cq    <= cmd;
                polls <= '0;
                fbusy <= 1'b0;
                err_q <= 1'b0;
            end
            if (sh_start) bcnt <= n_bcnt;
            if (st == S_POLL_RD && sh_done) fbusy <= sh_rx[0];
            if (st == S_GAP_POLL && fbusy) begin
                if (polls == POLL_LAST) err_q <= 1'b1;
                else                    polls <= polls + 1'b1;
            end
        end
    end

    always_comb begin
        busy      = (st != S_IDLE);
        cs_n      = !is_byte(st);
        done_p    = (st == S_END);
        err_p     = (st == S_END) && err_q;
        buf_we    = (st == S_DAT) && sh_done && !cq.kind[0];
        buf_widx  = bcnt;
        buf_wdata = sh_rx;
    end

    // R3
    adr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ADR) |-> (bcnt <= CNT_W'(2)));
    // R4
    dat_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DAT) |-> (bcnt <= cq.last_idx));
    // R7
    pfx_only_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PFX || st == S_POLL_OP) |-> cq.atomic);
    // R8
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_POLL_OP) |-> (polls <= POLL_LAST));
endmodule

// File: rtl/opm_spi_sequencer.sv
module opm_spi_sequencer
    import opm_pkg::*;
#(
    parameter int SCK_HALF   = 2,
    parameter int POLL_LIMIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_waddr,
    input  logic [31:0]   reg_wdata,
    input  logic [AW-1:0] reg_raddr,
    output logic [31:0]   reg_rdata,
    output logic          spi_sclk,
    output logic          spi_cs_n,
    output logic          spi_mosi,
    input  logic          spi_miso
);
    logic [15:0] pfx_q, types_q, ctl_q;
    logic [63:0] menu_q;
    logic [23:0] addr_q;
    logic        done_f, err_f, lock_q;
    logic [7:0]  dbuf [BUF_BYTES];

    logic             go, seq_busy, seq_done, seq_err;
    logic             sh_start, sh_done;
    logic [7:0]       sh_tx, sh_rx, buf_wdata;
    logic [CNT_W-1:0] buf_ridx, buf_widx;
    logic             buf_we;
    logic [2:0]       sel;
    cmd_t             cmd;

    assign go  = reg_we && (reg_waddr == RA_CTRL) && reg_wdata[1];
    assign sel = reg_wdata[6:4];

    always_comb begin
        cmd.opcode   = menu_q[{sel, 3'b000} +: 8];
        cmd.kind     = types_q[{sel, 1'b0} +: 2];
        cmd.prefix   = reg_wdata[3] ? pfx_q[15:8] : pfx_q[7:0];
        cmd.atomic   = reg_wdata[2];
        cmd.data_en  = reg_wdata[14];
        cmd.last_idx = reg_wdata[8 +: CNT_W];
        cmd.addr     = addr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pfx_q   <= '0;
            types_q <= '0;
            ctl_q   <= '0;
            menu_q  <= '0;
            addr_q  <= '0;
            done_f  <= 1'b0;
            err_f   <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            if (reg_we) begin
                case (reg_waddr)
                    RA_STATUS: begin
                        if (reg_wdata[2]) done_f <= 1'b0;
                        if (reg_wdata[3]) err_f  <= 1'b0;
                    end
                    RA_CTRL:    if (!seq_busy) ctl_q <= reg_wdata[15:0] & CTRL_KEEP;
                    RA_ADDR:    addr_q <= reg_wdata[23:0];
                    RA_PREFIX:  if (!lock_q) pfx_q <= reg_wdata[15:0];
                    RA_TYPES:   if (!lock_q) types_q <= reg_wdata[15:0];
                    RA_MENU_LO: if (!lock_q) menu_q[31:0] <= reg_wdata;
                    RA_MENU_HI: if (!lock_q) menu_q[63:32] <= reg_wdata;
                    RA_LOCK:    if (reg_wdata[0]) lock_q <= 1'b1;
                    default: ;
                endcase
            end
            if (seq_done) done_f <= 1'b1;
            if (seq_err)  err_f  <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_BYTES; i++) dbuf[i] <= '0;
        end else begin
            if (reg_we && reg_waddr[AW-1]) begin
                for (int b = 0; b < 4; b++)
                    dbuf[int'(reg_waddr[AW-2:0]) * 4 + b] <= reg_wdata[8*b +: 8];
            end
            if (buf_we) dbuf[buf_widx] <= buf_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_raddr[AW-1]) begin
            for (int b = 0; b < 4; b++)
                reg_rdata[8*b +: 8] = dbuf[int'(reg_raddr[AW-2:0]) * 4 + b];
        end else begin
            case (reg_raddr)
                RA_STATUS:  reg_rdata = {28'd0, err_f, done_f, 1'b0, seq_busy};
                RA_CTRL:    reg_rdata = {16'd0, ctl_q};
                RA_ADDR:    reg_rdata = {8'd0, addr_q};
                RA_PREFIX:  reg_rdata = {16'd0, pfx_q};
                RA_TYPES:   reg_rdata = {16'd0, types_q};
                RA_MENU_LO: reg_rdata = menu_q[31:0];
                RA_MENU_HI: reg_rdata = menu_q[63:32];
                RA_LOCK:    reg_rdata = {31'd0, lock_q};
                default:    reg_rdata = '0;
            endcase
        end
    end

    opm_seq #(.POLL_LIMIT(POLL_LIMIT)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .cmd(cmd),
        .buf_rdata(dbuf[buf_ridx]), .buf_ridx(buf_ridx),
        .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
        .busy(seq_busy), .done_p(seq_done), .err_p(seq_err), .cs_n(spi_cs_n),
        .sh_start(sh_start), .sh_tx(sh_tx), .sh_rx(sh_rx), .sh_done(sh_done)
    );

    opm_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .rx_byte(sh_rx), .byte_done(sh_done)
    );

    // R2
    cs_high_clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    // R11
    locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(menu_q) && $stable(types_q) && $stable(pfx_q) && lock_q));
    // R9
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (done_f && !seq_busy));
endmodule

// File: tb/opm_spi_sequencer_bench.sv
module opm_spi_sequencer_bench;
    localparam int POLLS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_waddr = '0;
    logic [4:0]  reg_raddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, cs_n, mosi, miso;

    int checks = 0;
    int fails = 0;
    int exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    opm_spi_sequencer #(.SCK_HALF(2), .POLL_LIMIT(POLLS)) u_opm_spi_sequencer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(spi_miso_w)
    );
    logic spi_miso_w;
    assign spi_miso_w = miso;

    // flash model: byte b of a frame answers 0xA0+b, status frames answer busy bit
    int         bitc = 0;
    int         busy_left = 0;
    bit         live = 0;
    logic [7:0] shin = '0;
    logic [7:0] first_b = '0;
    logic [7:0] resp_b;

    always_comb begin
        if (bitc < 8)                resp_b = 8'h00;
        else if (first_b == 8'h05)   resp_b = (busy_left > 0) ? 8'h01 : 8'h00;
        else                         resp_b = 8'hA0 + 8'(bitc / 8);
    end
    assign miso = resp_b[3'd7 - 3'(bitc % 8)];

    task automatic observe(int got);
        int e;
        string t;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R12 unexpected bus item actual=%0h expected=none", got);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (got != e) begin
                fails++;
                $display("FAIL %s bus item actual=%0h expected=%0h", t, got, e);
            end
        end
    endtask

    always @(negedge cs_n) bitc = 0;
    always @(posedge sclk) begin
        shin = {shin[6:0], mosi};
        bitc++;
        if (bitc % 8 == 0) begin
            if (bitc == 8) first_b = shin;
            observe(int'(shin));
        end
    end
    always @(posedge cs_n) begin
        if (live) begin
            observe(256);
            if (first_b == 8'h05 && busy_left > 0) busy_left--;
        end
    end

    task automatic push(int v, string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic check(string t, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", t, act, exp);
        end
    endtask

    task automatic reg_wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_raddr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            reg_rd(5'd0, s);
            if (s[2]) break;
        end
    endtask

    task automatic expect_cmd_addr(int op, string t);
        push(op, t); push(8'hAB, "R3"); push(8'hCD, "R3"); push(8'hEF, "R3");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        live = 1;
        // R1 reset state
        reg_rd(5'd0, v); check("R1 status", v, 32'h0);
        check("R1 cs_n", {31'd0, cs_n}, 32'h1);
        check("R1 sclk", {31'd0, sclk}, 32'h0);
        reg_rd(5'd5, v); check("R1 menu", v, 32'h0);
        reg_rd(5'd4, v); check("R1 kinds", v, 32'h0);

        // configuration
        reg_wr(5'd3, 32'h0000_5006);
        reg_wr(5'd4, 32'h0000_031B);
        reg_wr(5'd5, 32'h9F01_0302);
        reg_wr(5'd6, 32'h0000_00D8);
        reg_rd(5'd5, v); check("R11 menu before lock", v, 32'h9F010302);
        // R10 reserved address bits
        reg_wr(5'd2, 32'hFFAB_CDEF);
        reg_rd(5'd2, v); check("R10 address", v, 32'h00ABCDEF);

        // R3 R5 read with address, 4 bytes
        expect_cmd_addr(8'h03, "R2");
        for (int i = 0; i < 4; i++) push(8'h00, "R5");
        push(256, "R5");
        reg_wr(5'd1, 32'h0000_4312);
        wait_done();
        reg_rd(5'd16, v); check("R5 read data", v, 32'hA7A6A5A4);
        reg_rd(5'd0, v); check("R9 done set busy clear", v, 32'h4);
        reg_wr(5'd0, 32'h0);
        reg_rd(5'd0, v); check("R9 write zero keeps done", v, 32'h4);
        reg_wr(5'd0, 32'h4);
        reg_rd(5'd0, v); check("R9 done cleared", v, 32'h0);

        // R6 no data phase, count field ignored
        push(8'h9F, "R6"); push(256, "R6");
        reg_wr(5'd1, 32'h0000_3F32);
        wait_done();
        reg_wr(5'd0, 32'h4);

        // R4 write with address, 5 data bytes
        reg_wr(5'd16, 32'h4433_2211);
        reg_wr(5'd17, 32'h0000_0055);
        expect_cmd_addr(8'h02, "R2");
        push(8'h11, "R4"); push(8'h22, "R4"); push(8'h33, "R4");
        push(8'h44, "R4"); push(8'h55, "R4"); push(256, "R4");
        reg_wr(5'd1, 32'h0000_4402);
        wait_done();
        reg_wr(5'd0, 32'h4);

        // R7 atomic, prefix 0, two busy polls
        busy_left = 2;
        push(8'h06, "R7"); push(256, "R7");
        expect_cmd_addr(8'hD8, "R7"); push(256, "R7");
        for (int i = 0; i < 3; i++) begin push(8'h05, "R7"); push(8'h00, "R7"); push(256, "R7"); end
        reg_wr(5'd1, 32'h0000_0046);
        wait_done();
        reg_rd(5'd0, v); check("R7 done without error", v, 32'h4);
        reg_wr(5'd0, 32'h4);

        // R7 atomic, prefix 1, write kind without address, one byte
        push(8'h50, "R7"); push(256, "R7");
        push(8'h01, "R3"); push(8'h11, "R4"); push(256, "R7");
        push(8'h05, "R7"); push(8'h00, "R7"); push(256, "R7");
        reg_wr(5'd1, 32'h0000_402E);
        wait_done();
        reg_wr(5'd0, 32'h4);

        // R8 poll timeout
        busy_left = 100;
        push(8'h06, "R8"); push(256, "R8");
        expect_cmd_addr(8'hD8, "R8"); push(256, "R8");
        for (int i = 0; i < POLLS; i++) begin push(8'h05, "R8"); push(8'h00, "R8"); push(256, "R8"); end
        reg_wr(5'd1, 32'h0000_0046);
        wait_done();
        reg_rd(5'd0, v); check("R8 done and error", v, 32'hC);
        reg_wr(5'd0, 32'hC);
        reg_rd(5'd0, v); check("R9 both cleared", v, 32'h0);
        busy_left = 0;

        // R12 go while busy ignored, full 64-byte read (R5)
        expect_cmd_addr(8'h03, "R12");
        for (int i = 0; i < 64; i++) push(8'h00, "R5");
        push(256, "R12");
        reg_wr(5'd1, 32'h0000_7F12);
        repeat (100) @(negedge clk);
        reg_rd(5'd0, v); check("R9 busy during cycle", v, 32'h1);
        reg_wr(5'd1, 32'h0000_0032);
        wait_done();
        reg_rd(5'd31, v); check("R5 last buffer word", v, 32'hE3E2E1E0);
        reg_rd(5'd16, v); check("R5 first buffer word", v, 32'hA7A6A5A4);
        reg_wr(5'd0, 32'h4);

        // R11 lock
        reg_wr(5'd7, 32'h1);
        reg_wr(5'd5, 32'h1234_5678);
        reg_wr(5'd4, 32'h0);
        reg_wr(5'd3, 32'h0);
        reg_rd(5'd5, v); check("R11 menu frozen", v, 32'h9F010302);
        reg_rd(5'd4, v); check("R11 kinds frozen", v, 32'h0000031B);
        reg_rd(5'd3, v); check("R11 prefix frozen", v, 32'h00005006);
        push(8'h9F, "R11"); push(256, "R11");
        reg_wr(5'd1, 32'h0000_0032);
        wait_done();
        repeat (20) @(negedge clk);

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing bus items actual=%0d expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule